// File: doc/BRIEF.md
# Multiplier Busy Interlock

This block holds the decode stage of a five-stage in-order pipeline when an instruction there would collide with a shared multi-cycle multiplier. Each cycle it sees whether the decode slot holds a valid instruction, a two-bit class for that instruction, and a pipeline-advance enable. From these it drives a single stall line back to decode. It also tracks, in two small shadow stages for execute and memory access, any multiplier instruction already past decode.

A multiplier instruction keeps the multiplier occupied for a fixed number of cycles after its last memory-access slot, so its effect outlives its place in the pipeline. A busy counter loads when that last memory-access slot completes and counts down every cycle after that. Decode holds any later multiplier user while a multiplier instruction is still in execute or memory access, or while the counter is non-zero. The double-length multiply-accumulate takes two memory-access slots. The instruction right after it loses exactly one decode slot, whatever its class.

Top module: `mul_interlock`

## Requirements
- R1: Class encoding on `id_class`: 2'b00 is an instruction that does not use the multiplier. 2'b01 is a single-slot multiplier user (word multiply-accumulate, signed word or double-length multiply). 2'b11 is a transfer to or from the multiply result registers, which is also a single-slot user. 2'b10 is the double-length multiply-accumulate. An instruction issues in a cycle where `id_valid` and `advance` are 1 and `id_stall` is 0.
- R2: While a double-length multiply-accumulate sits in execute, any valid decode instruction is stalled. This is a one-slot stall.
- R3: A non-multiplier instruction is never stalled except by the one-slot rule of R2. After that slot it issues at once.
- R4: A multiplier user in decode is stalled while a multiplier instruction is in execute or memory access.
- R5: When the final memory-access slot of a multiplier instruction completes, `busy_left` shows BUSY_CYCLES (default 4) in the next cycle.
- R6: `busy_left` drops by one each cycle until it reaches zero, whether or not `advance` is 1. A multiplier user stays stalled while `busy_left` is non-zero. With default parameters, a user directly behind a single-slot user stalls 6 cycles.
- R7: The double-length multiply-accumulate occupies memory access for two slots. A multiplier user directly behind it stalls 7 cycles.
- R8: The one-slot stall and the contention stall combine by OR. Two double-length multiply-accumulates back to back give 7 stall cycles, not 8.
- R9: While `advance` is 0, the execute and memory-access stages hold their contents and nothing issues.
- R10: A synchronous active-high `rst` clears `busy_left` and both tracking stages, so a multiplier user presented right after reset issues without a stall.
- R11: `id_stall` is 0 whenever `id_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| id_valid | input | 1 | Decode slot holds an instruction |
| id_class | input | 2 | Class of the decode instruction (R1 encoding) |
| advance | input | 1 | Pipeline advance enable |
| id_stall | output | 1 | Hold the decode instruction this cycle |
| busy_left | output | $clog2(BUSY_CYCLES+1) | Remaining multiplier busy cycles |

## Verification
The bench targets users stacked directly behind single-slot and double-length multiplier instructions. A design that dropped the second memory-access slot would release those users one cycle early. A design that added the one-slot and contention stalls instead of ORing them would show 8 cycles for two double-length operations back to back. It also checks that a non-multiplier instruction behind a multiplier operation passes freely, which catches an interlock that over-stalls. It checks that the counter keeps counting while `advance` is low and that reset in mid-busy frees the multiplier, which catches a counter gated by the wrong enable or left out of reset.

// File: rtl/mul_interlock.sv
module mul_interlock #(
  parameter int BUSY_CYCLES = 4,
  localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          id_valid,
  input  logic [1:0]    id_class,
  input  logic          advance,
  output logic          id_stall,
  output logic [CW-1:0] busy_left
);

  logic id_user, id_long, issue;
  logic ex_mul, ex_long;
  logic ma_mul, ma_long, ma_first;
  logic ma_done;

  assign id_user = id_class != 2'b00;
  assign id_long = id_class == 2'b10;

  assign id_stall = id_valid &
                    (ex_long | (id_user & (ex_mul | ma_mul | (busy_left != '0))));
  assign issue    = id_valid & advance & ~id_stall;
  assign ma_done  = advance & ma_mul & ~(ma_long & ma_first);

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_mul   <= 1'b0;
      ex_long  <= 1'b0;
      ma_mul   <= 1'b0;
      ma_long  <= 1'b0;
      ma_first <= 1'b0;
    end else if (advance) begin
      ex_mul  <= issue & id_user;
      ex_long <= issue & id_long;
      if (ma_long && ma_first) begin
        ma_first <= 1'b0;
      end else begin
        ma_mul   <= ex_mul;
        ma_long  <= ex_long;
        ma_first <= ex_long;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      busy_left <= '0;
    else if (ma_done)
      busy_left <= CW'(BUSY_CYCLES);
    else if (busy_left != '0)
      busy_left <= busy_left - CW'(1);
  end

endmodule

module mul_interlock_chk #(
  parameter int BUSY_CYCLES = 4,
  localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          id_valid,
  input logic [1:0]    id_class,
  input logic          advance,
  input logic          id_stall,
  input logic [CW-1:0] busy_left,
  input logic          ex_mul,
  input logic          ex_long,
  input logic          ma_mul,
  input logic          ma_done
);

  AST_LONG_GAP: assert property (@(posedge clk) disable iff (rst)
    id_valid && ex_long |-> id_stall); // R2
  AST_NONUSER_PASS: assert property (@(posedge clk) disable iff (rst)
    id_valid && id_class == 2'b00 && !ex_long |-> !id_stall); // R3
  AST_INFLIGHT_HOLD: assert property (@(posedge clk) disable iff (rst)
    id_valid && id_class != 2'b00 && (ex_mul || ma_mul) |-> id_stall); // R4
  AST_BUSY_LOAD: assert property (@(posedge clk) disable iff (rst)
    ma_done |=> busy_left == CW'(BUSY_CYCLES)); // R5
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    busy_left != '0 && !ma_done |=> busy_left == CW'($past(busy_left) - CW'(1))); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    id_valid && id_class != 2'b00 && busy_left != '0 |-> id_stall); // R6
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(ex_mul) && $stable(ex_long)); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> busy_left == '0 && !ex_mul && !ma_mul); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !id_valid |-> !id_stall); // R11

endmodule

bind mul_interlock mul_interlock_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .id_valid(id_valid), .id_class(id_class),
  .advance(advance), .id_stall(id_stall), .busy_left(busy_left),
  .ex_mul(ex_mul), .ex_long(ex_long), .ma_mul(ma_mul), .ma_done(ma_done)
);

// File: tb/mul_interlock_test.sv
`timescale 1ns/100ps
module mul_interlock_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       id_valid = 1'b0;
  logic [1:0] id_class = 2'b00;
  logic       advance = 1'b1;
  logic       id_stall;
  logic [2:0] busy_left;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mul_interlock uut (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_class(id_class),
    .advance(advance), .id_stall(id_stall), .busy_left(busy_left)
  );

  // {valid, class[1:0], expected stall cycles[3:0]}, advance held high
  localparam int NV = 13;
  localparam logic [6:0] VEC [NV] = '{
    {1'b1, 2'b01, 4'd0},  // first user, idle unit
    {1'b1, 2'b01, 4'd6},  // user behind user (R6)
    {1'b1, 2'b00, 4'd0},  // non-user behind user (R3)
    {1'b1, 2'b10, 4'd5},  // long behind user
    {1'b1, 2'b00, 4'd1},  // non-user behind long (R2)
    {1'b1, 2'b01, 4'd5},  // user two slots behind long (R7)
    {1'b0, 2'b00, 4'd0},  // empty slot (R11)
    {1'b1, 2'b10, 4'd5},
    {1'b1, 2'b10, 4'd7},  // long behind long (R7, R8)
    {1'b0, 2'b00, 4'd0},
    {1'b1, 2'b11, 4'd6},  // transfer one slot behind long (R1)
    {1'b1, 2'b00, 4'd0},
    {1'b1, 2'b01, 4'd5}   // user one slot behind transfer (R4)
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // present one instruction from a negedge, count stall cycles until it issues
  task automatic present(input bit v, input logic [1:0] c, output int n);
    n = 0;
    id_valid = v;
    id_class = c;
    for (int k = 0; k < 20; k++) begin
      #1;
      if (!id_stall) break;
      n++;
      @(negedge clk);
    end
    @(negedge clk);
    id_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(busy_left == 3'd0, "R10 reset busy_left", busy_left, 0);
    check(id_stall == 1'b0, "R10 reset stall", id_stall, 0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      present(VEC[i][6], VEC[i][5:4], n);
      check(n == int'(VEC[i][3:0]), $sformatf("R1-vector%0d stall count (R4 R6 R7 R8)", i),
            n, VEC[i][3:0]);
    end

    // drain, then counter visibility (R5)
    repeat (10) @(negedge clk);
    present(1'b1, 2'b01, n);     // issues at t; now at t+1 negedge
    @(negedge clk);              // t+2: in MA
    #1;
    check(busy_left == 3'd0, "R5 not yet loaded", busy_left, 0);
    @(negedge clk);              // t+3
    #1;
    check(busy_left == 3'd4, "R5 loaded", busy_left, 4);
    @(negedge clk);              // t+4 with advance low
    advance = 1'b0;
    #1;
    check(busy_left == 3'd3, "R6 counts with advance high", busy_left, 3);
    @(negedge clk);              // t+5
    #1;
    check(busy_left == 3'd2, "R6 counts with advance low", busy_left, 2);
    advance = 1'b1;
    repeat (4) @(negedge clk);

    // freeze: user issues, advance low 3 cycles, follower stalls 9 (R9)
    present(1'b1, 2'b01, n);
    advance = 1'b0;
    id_valid = 1'b1;
    id_class = 2'b01;
    n = 0;
    for (int k = 0; k < 3; k++) begin
      #1;
      if (id_stall) n++;
      @(negedge clk);
    end
    advance = 1'b1;
    for (int k = 0; k < 20; k++) begin
      #1;
      if (!id_stall) break;
      n++;
      @(negedge clk);
    end
    check(n == 9, "R9 frozen stages stall count", n, 9);
    @(negedge clk);
    id_valid = 1'b0;
    repeat (10) @(negedge clk);

    // reset during busy window (R10)
    present(1'b1, 2'b10, n);
    repeat (3) @(negedge clk);
    #1;
    check(busy_left == 3'd4, "R10 busy before reset", busy_left, 4);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    present(1'b1, 2'b01, n);
    check(n == 0, "R10 user after reset", n, 0);

    // empty slot while long in execute (R11)
    present(1'b1, 2'b10, n);
    id_valid = 1'b0;
    id_class = 2'b01;
    #1;
    check(id_stall == 1'b0, "R11 invalid slot", id_stall, 0);
    repeat (12) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule